// File: doc/BRIEF.md
# Sample-Rate Clock and Serial Codec Port

This block divides the master oscillator down to one of eight sample rates. It runs a 16-bit serial link to an external converter pair. One output toggles at the sample rate and doubles as the frame sync. A bit clock carries sixteen bit slots per frame. One line sends the outgoing sample and a separate line captures the incoming one.

The parallel side works by frame. The word on `tx_sample_i` is latched at the start of each frame and shifted out during that frame. The word collected on `ser_din_i` is presented on `rx_sample_o` with a one-cycle `frame_done_o` pulse as the next frame begins.

Six rate codes assume a 4.096 MHz master clock and two assume 5.6448 MHz. The three fastest rates are for playback only, so a configuration that asks for one of them in record mode is refused.

Top module: `sc_codec_port`

## Requirements
- R1: While `rst_n` is low, and from the first clock edge at which `run_i` is sampled low, `fs_o`, `bclk_o`, `ser_dout_o` and `frame_done_o` are 0. Reset also clears `rx_sample_o` and `cfg_reject_o`.
- R2: The frame length in master clock cycles follows the active rate code. Codes 0 to 5 give 1024, 640, 512, 320, 256 and 128, which are 4.0, 6.4, 8.0, 12.8, 16.0 and 32.0 kHz at 4.096 MHz. Codes 6 and 7 give 256 and 128, which are 22.05 and 44.1 kHz at 5.6448 MHz. After reset the active code is 2.
- R3: Each frame holds 16 bit clock periods of N/16 cycles each. The bit clock is low for the first half of each period and high for the second half, so it is high for N/2 cycles per frame.
- R4: `fs_o` is high for the first 8 bit periods of a frame and low for the last 8. It changes only while `bclk_o` is low.
- R5: `ser_dout_o` sends the latched word MSB first, one bit per bit period. It changes only while `bclk_o` is low.
- R6: `ser_din_i` is sampled at each rising edge of the bit clock. The 16 samples form the received word, first sample in bit 15.
- R7: Once per frame, `frame_done_o` pulses for exactly one cycle. The pulse falls in the first cycle of the next frame, while `fs_o` is 1 and `bclk_o` is 0. In the same cycle `rx_sample_o` shows the word received in the frame just ended.
- R8: A load with `cfg_record_i`=1 and a rate code of 5, 6 or 7 is refused. `cfg_reject_o` is 1 in the cycle after the load, and the active rate and the frame timing do not change. Record loads with codes 0 to 4 are accepted with no reject pulse.
- R9: An accepted load while running restarts the frame. In the next cycle `fs_o` is 1 and `bclk_o` is 0, and the first `frame_done_o` follows exactly N cycles after that cycle, at the new rate.
- R10: The word sent in a frame is the value of `tx_sample_i` in the last cycle of the previous frame, or in the cycle the frame was started. A change made in the pulse cycle is sent in the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | 1 runs the frame timing; 0 idles the link |
| cfg_load_i | input | 1 | One-cycle strobe that applies a rate configuration |
| cfg_rate_i | input | 3 | Rate code, see R2 |
| cfg_record_i | input | 1 | 1 marks the configuration as record mode |
| tx_sample_i | input | 16 | Sample to send in the next frame |
| ser_din_i | input | 1 | Serial data from the external converter |
| fs_o | output | 1 | Sample-rate clock and frame sync |
| bclk_o | output | 1 | Serial bit clock |
| ser_dout_o | output | 1 | Serial data to the external converter |
| rx_sample_o | output | 16 | Last received sample |
| frame_done_o | output | 1 | One-cycle pulse marking a completed frame |
| cfg_reject_o | output | 1 | One-cycle pulse marking a refused configuration |

## Verification
A refused load shows its reject pulse one cycle after the strobe. The frame restart after an accepted load shows in that same cycle. The first completion pulse then comes N cycles later, and every later pulse N cycles after the one before. The idle state appears one cycle after `run_i` drops.

The bench samples every output on the falling edge of the clock. It counts those sample points from the cycle a stimulus takes effect, so each figure is compared at the exact cycle where it is due. Frame statistics cover the cycles strictly between two completion pulses: bit clock rises, high cycles of both clocks, and the bits seen on the data line at each rise.

// File: rtl/sc_pkg.sv
// Package: shared types and rate tables for the serial codec port.
// Assumes rate codes 0..5 run from a 4.096 MHz master clock and 6..7 from 5.6448 MHz.
package sc_pkg;

    localparam int unsigned RATE_W  = 3;
    localparam int unsigned MAX_DIV = 1024;

    typedef logic [RATE_W-1:0] rate_code_t;

    // Lowest code that is restricted to playback.
    localparam rate_code_t FIRST_PLAY_ONLY = 3'd5;

    // Master clock cycles per frame for a given rate code.
    function automatic int unsigned frame_div(input rate_code_t code);
        case (code)
            3'd0:    return 1024;
            3'd1:    return 640;
            3'd2:    return 512;
            3'd3:    return 320;
            3'd4:    return 256;
            3'd5:    return 128;
            3'd6:    return 256;
            default: return 128;
        endcase
    endfunction

    // High when a code may not be used for recording.
    function automatic logic play_only(input rate_code_t code);
        return code >= FIRST_PLAY_ONLY;
    endfunction

endpackage

// File: rtl/sc_rate_cfg.sv
// Module: holds the active rate code, screens record-mode loads and derives
// the per-bit phase limits. Assumes frame_div is a multiple of 2*SAMPLE_W.
module sc_rate_cfg
    import sc_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned PH_W     = 6,
    parameter int unsigned DEF_RATE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load_i,
    input  rate_code_t       cfg_rate_i,
    input  logic             cfg_record_i,
    output rate_code_t       rate_o,
    output logic             apply_o,
    output logic             reject_o,
    output logic [PH_W-1:0]  last_ph_o,
    output logic [PH_W-1:0]  half_ph_o
);

    localparam rate_code_t RESET_CODE = rate_code_t'(DEF_RATE);

    rate_code_t  rate_q;
    logic        reject_q;
    int unsigned bit_period;

    // Decide whether a load is accepted.
    always_comb begin
        apply_o = cfg_load_i & ~(cfg_record_i & play_only(cfg_rate_i));
    end

    // Store the accepted code and flag refused loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= RESET_CODE;
            reject_q <= 1'b0;
        end else begin
            reject_q <= cfg_load_i & ~apply_o;
            if (apply_o) begin
                rate_q <= cfg_rate_i;
            end
        end
    end

    // Turn the active code into bit-period limits.
    always_comb begin
        bit_period = frame_div(rate_q) / SAMPLE_W;
        last_ph_o  = PH_W'(bit_period - 1);
        half_ph_o  = PH_W'(bit_period / 2);
    end

    assign rate_o   = rate_q;
    assign reject_o = reject_q;

endmodule

// File: rtl/sc_bit_timer.sv
// Module: two-level divider (phase within bit, bit within frame) that produces
// the bit clock, the frame sync and the shift/sample/wrap events.
// Assumes last_ph_i > half_ph_i > 0 and that both are stable except at a restart.
module sc_bit_timer #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned PH_W     = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            start_i,
    input  logic [PH_W-1:0] last_ph_i,
    input  logic [PH_W-1:0] half_ph_i,
    output logic            run_o,
    output logic            bclk_o,
    output logic            fs_o,
    output logic            wrap_o,
    output logic            shift_o,
    output logic            sample_o
);

    localparam int unsigned      BIT_W    = $clog2(SAMPLE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);
    localparam logic [BIT_W-1:0] FS_BITS  = BIT_W'(SAMPLE_W / 2);

    logic [PH_W-1:0]  ph_q;
    logic [BIT_W-1:0] bit_q;
    logic             run_q;
    logic             bclk_q;
    logic             fs_q;
    logic             live;
    logic             ph_end;
    logic             bit_end;
    logic [BIT_W-1:0] bit_nx;

    // Decode the current position in the frame.
    always_comb begin
        live    = run_q & run_i & ~start_i;
        ph_end  = (ph_q == last_ph_i);
        bit_end = (bit_q == LAST_BIT);
        bit_nx  = bit_end ? '0 : bit_q + BIT_W'(1);
    end

    // Advance the counters and the registered clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            ph_q   <= '0;
            bit_q  <= '0;
            run_q  <= 1'b0;
            bclk_q <= 1'b0;
            fs_q   <= 1'b0;
        end else if (start_i) begin
            ph_q   <= '0;
            bit_q  <= '0;
            run_q  <= 1'b1;
            bclk_q <= 1'b0;
            fs_q   <= 1'b1;
        end else if (ph_end) begin
            ph_q   <= '0;
            bit_q  <= bit_nx;
            bclk_q <= 1'b0;
            fs_q   <= (bit_nx < FS_BITS);
        end else begin
            ph_q <= ph_q + PH_W'(1);
            if (ph_q + PH_W'(1) == half_ph_i) begin
                bclk_q <= 1'b1;
            end
        end
    end

    assign run_o    = run_q;
    assign bclk_o   = bclk_q;
    assign fs_o     = fs_q;
    assign wrap_o   = live & ph_end & bit_end;
    assign shift_o  = live & ph_end & ~bit_end;
    assign sample_o = live & (ph_q == half_ph_i);

endmodule

// File: rtl/sc_serdes.sv
// Module: parallel/serial shifter pair. Loads the outgoing word at a frame
// start, shifts it MSB first, collects incoming bits and publishes them.
// Assumes the event inputs come from sc_bit_timer and are mutually exclusive.
module sc_serdes #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                start_i,
    input  logic                wrap_i,
    input  logic                shift_i,
    input  logic                sample_i,
    input  logic [SAMPLE_W-1:0] tx_sample_i,
    input  logic                ser_din_i,
    output logic                ser_dout_o,
    output logic [SAMPLE_W-1:0] rx_sample_o,
    output logic                done_o
);

    logic [SAMPLE_W-1:0] tx_q;
    logic [SAMPLE_W-1:0] rx_q;
    logic [SAMPLE_W-1:0] word_q;
    logic                done_q;

    // Load, shift and capture per the timer events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else if (!run_i) begin
            tx_q   <= '0;
            rx_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= wrap_i;
            if (start_i) begin
                tx_q <= tx_sample_i;
                rx_q <= '0;
            end else if (wrap_i) begin
                tx_q   <= tx_sample_i;
                word_q <= rx_q;
                rx_q   <= '0;
            end else begin
                if (shift_i) begin
                    tx_q <= {tx_q[SAMPLE_W-2:0], 1'b0};
                end
                if (sample_i) begin
                    rx_q <= {rx_q[SAMPLE_W-2:0], ser_din_i};
                end
            end
        end
    end

    assign ser_dout_o  = tx_q[SAMPLE_W-1];
    assign rx_sample_o = word_q;
    assign done_o      = done_q;

endmodule

// File: rtl/sc_codec_port.sv
// Module: top of the sample-rate clock and serial codec port. Joins the rate
// configuration, the bit timer and the shifters. Assumes a single master clock
// domain; the external converters sample the outputs of this block directly.
module sc_codec_port
    import sc_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned DEF_RATE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                cfg_load_i,
    input  logic [2:0]          cfg_rate_i,
    input  logic                cfg_record_i,
    input  logic [SAMPLE_W-1:0] tx_sample_i,
    input  logic                ser_din_i,
    output logic                fs_o,
    output logic                bclk_o,
    output logic                ser_dout_o,
    output logic [SAMPLE_W-1:0] rx_sample_o,
    output logic                frame_done_o,
    output logic                cfg_reject_o
);

    localparam int unsigned PH_W = $clog2(MAX_DIV / SAMPLE_W);

    rate_code_t      rate_code;
    logic            cfg_apply;
    logic [PH_W-1:0] last_ph;
    logic [PH_W-1:0] half_ph;
    logic            run_q;
    logic            start;
    logic            wrap_evt;
    logic            shift_evt;
    logic            sample_evt;

    sc_rate_cfg #(
        .SAMPLE_W (SAMPLE_W),
        .PH_W     (PH_W),
        .DEF_RATE (DEF_RATE)
    ) i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load_i   (cfg_load_i),
        .cfg_rate_i   (cfg_rate_i),
        .cfg_record_i (cfg_record_i),
        .rate_o       (rate_code),
        .apply_o      (cfg_apply),
        .reject_o     (cfg_reject_o),
        .last_ph_o    (last_ph),
        .half_ph_o    (half_ph)
    );

    // Begin a frame on the first running cycle or after an accepted load.
    always_comb begin
        start = run_i & (~run_q | cfg_apply);
    end

    sc_bit_timer #(
        .SAMPLE_W (SAMPLE_W),
        .PH_W     (PH_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .start_i   (start),
        .last_ph_i (last_ph),
        .half_ph_i (half_ph),
        .run_o     (run_q),
        .bclk_o    (bclk_o),
        .fs_o      (fs_o),
        .wrap_o    (wrap_evt),
        .shift_o   (shift_evt),
        .sample_o  (sample_evt)
    );

    sc_serdes #(
        .SAMPLE_W (SAMPLE_W)
    ) i_serdes (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .start_i     (start),
        .wrap_i      (wrap_evt),
        .shift_i     (shift_evt),
        .sample_i    (sample_evt),
        .tx_sample_i (tx_sample_i),
        .ser_din_i   (ser_din_i),
        .ser_dout_o  (ser_dout_o),
        .rx_sample_o (rx_sample_o),
        .done_o      (frame_done_o)
    );

endmodule

// File: rtl/sc_codec_port_chk.sv
// Checker: temporal properties of the codec port, bound into every instance.
module sc_codec_port_chk
    import sc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       run_i,
    input logic       cfg_load_i,
    input logic [2:0] cfg_rate_i,
    input logic       cfg_record_i,
    input logic       fs_o,
    input logic       bclk_o,
    input logic       ser_dout_o,
    input logic       frame_done_o,
    input logic       cfg_reject_o,
    input logic [2:0] rate_code
);

    // R1: idle outputs one cycle after run is sampled low
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!bclk_o && !fs_o && !ser_dout_o && !frame_done_o));

    // R4: frame sync moves only while the bit clock is low
    a_r4_fs_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o != $past(fs_o)) |-> !bclk_o);

    // R5: serial data moves only while the bit clock is low
    a_r5_dout_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_dout_o != $past(ser_dout_o)) |-> !bclk_o);

    // R7: single-cycle completion pulse at the head of a frame
    a_r7_done_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (fs_o && !bclk_o && !$past(frame_done_o)));

    // R8: a refused load leaves the active rate alone
    a_r8_reject_holds_rate: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reject_o |-> (rate_code == $past(rate_code)));

    // R9: an accepted load while running restarts the frame
    a_r9_restart_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cfg_load_i && !(cfg_record_i && play_only(cfg_rate_i)))
        |=> (fs_o && !bclk_o && !frame_done_o));

endmodule

bind sc_codec_port sc_codec_port_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .cfg_load_i   (cfg_load_i),
    .cfg_rate_i   (cfg_rate_i),
    .cfg_record_i (cfg_record_i),
    .fs_o         (fs_o),
    .bclk_o       (bclk_o),
    .ser_dout_o   (ser_dout_o),
    .frame_done_o (frame_done_o),
    .cfg_reject_o (cfg_reject_o),
    .rate_code    (rate_code)
);

// File: tb/test_sc_codec_port.sv
// Bench: random rates and words over a looped-back serial link, plus directed
// reset, refusal and restart cases. Outputs are sampled on the falling edge.
module test_sc_codec_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        load = 1'b0;
    logic [2:0]  rate = 3'd0;
    logic        rec = 1'b0;
    logic [15:0] tx = 16'd0;
    logic        inv_din = 1'b0;
    logic        din;
    logic        fs, bclk, dout, done, reject;
    logic [15:0] rx;

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign din = dout ^ inv_din;

    sc_codec_port i_sc_codec_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .cfg_load_i   (load),
        .cfg_rate_i   (rate),
        .cfg_record_i (rec),
        .tx_sample_i  (tx),
        .ser_din_i    (din),
        .fs_o         (fs),
        .bclk_o       (bclk),
        .ser_dout_o   (dout),
        .rx_sample_o  (rx),
        .frame_done_o (done),
        .cfg_reject_o (reject)
    );

    function automatic int exp_div(input logic [2:0] code);
        case (code)
            3'd0: return 1024;
            3'd1: return 640;
            3'd2: return 512;
            3'd3: return 320;
            3'd4: return 256;
            3'd6: return 256;
            default: return 128;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic load_cfg(input logic [2:0] code, input logic record);
        @(negedge clk);
        load = 1'b1; rate = code; rec = record;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!done && guard < 5000);
    endtask

    task automatic count_to_done(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!done && cnt < 5000);
    endtask

    task automatic idle_check(input string req);
        chk({req, " idle outputs"}, {28'd0, fs, bclk, dout, done}, 32'd0);
    endtask

    // Run nfr frames at a rate over the loopback and check each one.
    task automatic do_frames(input logic [2:0] code, input int nfr, input logic inv);
        logic [15:0] q[$];
        logic [15:0] w, expw, mon;
        int cyc, rises, bhi, fhi, bad, n;
        logic pb, pd;
        n = exp_div(code);
        @(negedge clk);
        run = 1'b0;
        load_cfg(code, 1'b0);
        inv_din = inv;
        w = 16'($urandom); tx = w; q.push_back(w);
        run = 1'b1;
        @(negedge clk);
        w = 16'($urandom); tx = w; q.push_back(w);
        cyc = 0; rises = 0; bad = 0; mon = '0;
        bhi = bclk ? 1 : 0; fhi = fs ? 1 : 0; pb = bclk; pd = dout;
        for (int f = 0; f < nfr; f++) begin
            do begin
                @(negedge clk);
                cyc++;
                if (!done) begin
                    if (bclk && !pb) begin rises++; mon = {mon[14:0], dout}; end
                    if (dout != pd && bclk) bad++;
                    if (bclk) bhi++;
                    if (fs) fhi++;
                    pb = bclk; pd = dout;
                end
            end while (!done && cyc < 4 * n);
            expw = q.pop_front();
            chk("R2 frame length", cyc, n);
            chk("R3 bit clock rises", rises, 16);
            chk("R3 bit clock high cycles", bhi, n / 2);
            chk("R4 frame sync high cycles", fhi, n / 2);
            chk("R5 MSB-first word on the line", mon, expw);
            chk("R5 data stable while bit clock high", bad, 0);
            chk("R6 received word", rx, expw ^ {16{inv}});
            chk("R7 pulse at frame head", {fs, bclk}, 2'b10);
            cyc = 0; rises = 0; bad = 0; mon = '0;
            bhi = 0; fhi = 1; pb = bclk; pd = dout;
            w = 16'($urandom); tx = w; q.push_back(w);   // R10: taken at next boundary
        end
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        idle_check("R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        idle_check("R1 in reset");
        chk("R1 rx cleared", rx, 16'd0);
        chk("R1 reject cleared", reject, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        idle_check("R1 after reset");

        // Default rate after reset (R2)
        run = 1'b1;
        @(negedge clk);
        count_to_done(cnt);
        chk("R2 default rate", cnt, 512);
        run = 1'b0;

        // Every rate code once (R2..R7, R10)
        for (int c = 0; c < 8; c++) begin
            do_frames(3'(c), 2, 1'b0);
        end
        // Inverted input and random mixes (R6)
        do_frames(3'd5, 3, 1'b1);
        for (int i = 0; i < 8; i++) begin
            do_frames(3'($urandom_range(0, 7)), $urandom_range(1, 3), 1'($urandom_range(0, 1)));
        end

        // Record-mode refusal and restart (R8, R9)
        load_cfg(3'd2, 1'b1);
        chk("R8 record code 2 allowed", reject, 1'b0);
        run = 1'b1;
        wait_done();
        load_cfg(3'd6, 1'b1);
        chk("R8 record code 6 refused", reject, 1'b1);
        wait_done();
        count_to_done(cnt);
        chk("R8 rate kept after refusal", cnt, 512);
        load_cfg(3'd6, 1'b0);
        chk("R9 playback code 6 accepted", reject, 1'b0);
        chk("R9 frame restarted", {fs, bclk}, 2'b10);
        count_to_done(cnt);
        chk("R9 first frame at new rate", cnt, 256);
        load_cfg(3'd1, 1'b1);
        chk("R9 record code 1 accepted", reject, 1'b0);
        count_to_done(cnt);
        chk("R9 restart at code 1", cnt, 640);
        load_cfg(3'd7, 1'b1);
        chk("R8 record code 7 refused", reject, 1'b1);
        wait_done();
        count_to_done(cnt);
        chk("R8 rate kept after second refusal", cnt, 640);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        idle_check("R1 after stop");

        report();
        $finish;
    end

endmodule